// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration space of one peripheral function. A requester reaches it through a single-cycle request port. Each request carries a 24-bit configuration address (bus number, device/function number and byte offset), an access length of 1, 2 or 4 bytes, and write data when it is a write. The block answers accesses whose bus and device/function fields match its own parameters. Accesses that do not match read back as all ones and write nothing.

Each byte has its own write mask and reset value, both computed from parameters. A written byte keeps its masked-off bits and takes the masked-in bits from the request. The masks of the base-address registers come from power-of-two region sizes, so writing all ones to such a register and reading it back reveals the region size. Reads are little-endian. A wide read near the top of the space is narrowed so that it never runs past offset 0xFF.

The block also raises a one-cycle remap pulse whenever a write really changes state that an address decoder downstream depends on. That pulse tells the surrounding logic to rebuild its decode windows.

Top module: `cfg_space`

## Requirements
- R1: A request matches only when address bits [23:16] equal the bus parameter and bits [15:8] equal the device/function parameter. A read that misses returns all ones at the requested width: 0xFF for length code 1, 0xFFFF for code 2, and 0xFFFFFFFF for any other code, which is treated as 4 bytes.
- R2: A write that misses leaves every byte of the space unchanged.
- R3: A 4-byte read at an offset above 0xFC returns only 2 bytes. A 2-byte read (requested, or narrowed by the first rule) at an offset above 0xFE returns only 1 byte. Unused upper bits of the read data are zero.
- R4: Read data is little-endian: the byte at the offset sits in bits [7:0], the next byte in bits [15:8], and so on. `rsp_vld` and `rsp_rdata` appear in the cycle after a read request, and `rsp_vld` stays low after writes and idle cycles.
- R5: Write lane k (write-data bits [8k+7:8k]) goes to offset+k. Each byte becomes (old AND NOT mask) OR (new AND mask). Lanes that would pass offset 0xFF are dropped.
- R6: Base-address register i (i = 0..5) sits at offset 0x10+4i. Its write mask is NOT(size-1) for a size of 2^BAR_LOG2[i]. A slot with BAR_LOG2 of 0 is wholly read-only. An I/O slot (BAR_IO[i] = 1) resets with bit 0 set, and that bit is read-only.
- R7: The expansion ROM register at offset 0x30 has the mask NOT(size-1) for a size of 2^ROM_LOG2, and its bit 0 (enable) is also writable.
- R8: In the command byte at offset 0x04, only bits [2:0] are writable. Offsets 0x0C and 0x3C, and every offset from 0x40 to 0xFF, are fully writable. All other header bytes are read-only.
- R9: `remap_pulse` is high for one cycle, in the cycle after a matching write, exactly when that write changed any byte in 0x10..0x27 or toggled bit 0 or bit 1 of the command byte. It is never high otherwise.
- R10: After reset, offsets 0x00-0x01 hold the vendor identifier and 0x02-0x03 the device identifier, both little-endian. Offset 0x08 holds the revision, 0x09-0x0B the class code, 0x3D the interrupt pin, and the first byte of an I/O base-address slot holds 0x01. Every other byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus [23:16], device/function [15:8], offset [7:0] |
| req_len | input | 3 | Length code: 1, 2, otherwise 4 bytes |
| req_wdata | input | 32 | Write data, lane 0 in bits [7:0] |
| rsp_vld | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| remap_pulse | output | 1 | Decode-relevant state changed |

## Verification
The bench builds the block with bus 0x02 and device/function 0x40, so requests to bus 0 or to other slots exercise the miss path. It gives the base-address slots sizes of 32 bytes (I/O), 4 KiB, 1 MiB, empty, 256 bytes (I/O) and empty. The 1 MiB slot masks part of its third byte. The empty slots show the read-only zero case. Both I/O slots carry the read-only type bit. A 2 KiB ROM gives a mask that splits its second byte, with the enable bit added.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int unsigned CFG_BYTES = 256;
    localparam int unsigned BAR_SLOTS = 6;
    localparam int unsigned BAR_BASE  = 16;
    localparam int unsigned ROM_BASE  = 48;
    localparam int unsigned CMD_OFF   = 4;
    localparam int unsigned BAR_TOP   = BAR_BASE + 4 * BAR_SLOTS - 1;

    typedef logic [CFG_BYTES-1:0][7:0] cfg_arr_t;

    typedef enum logic [1:0] {
        W1 = 2'd0,
        W2 = 2'd1,
        W4 = 2'd2
    } width_e;

    typedef struct packed {
        cfg_arr_t    cfg;
        logic [31:0] rdata;
        logic        rsp_vld;
        logic        remap;
    } cfg_state_t;

    function automatic width_e width_of(input logic [2:0] len);
        case (len)
            3'd1:    return W1;
            3'd2:    return W2;
            default: return W4;
        endcase
    endfunction

    function automatic logic [2:0] nbytes_of(input width_e w);
        case (w)
            W1:      return 3'd1;
            W2:      return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] ones_of(input width_e w);
        case (w)
            W1:      return 32'h0000_00FF;
            W2:      return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_pkg::*;
#(
    parameter logic [7:0] BUS_NUM = 8'h00,
    parameter logic [7:0] DEVFN   = 8'h00
) (
    input  logic [23:0] addr,
    input  logic [2:0]  len,
    output logic        hit,
    output logic [7:0]  off,
    output width_e      req_w,
    output width_e      rd_w
);

    always_comb begin
        hit   = (addr[23:16] == BUS_NUM) && (addr[15:8] == DEVFN);
        off   = addr[7:0];
        req_w = width_of(len);
        rd_w  = req_w;
        if (rd_w == W4 && off > 8'hFC) begin
            rd_w = W2;
        end
        if (rd_w == W2 && off > 8'hFE) begin
            rd_w = W1;
        end
    end

endmodule

// File: rtl/cfg_attr.sv
module cfg_attr
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h0000,
    parameter logic [15:0] DEVICE_ID = 16'h0000,
    parameter logic [7:0]  REVISION  = 8'h00,
    parameter logic [23:0] CLASS_CODE = 24'h000000,
    parameter logic [7:0]  INT_PIN   = 8'h00,
    parameter int unsigned BAR_LOG2 [BAR_SLOTS] = '{5, 12, 0, 0, 0, 0},
    parameter logic [BAR_SLOTS-1:0] BAR_IO = 6'b000001,
    parameter int unsigned ROM_LOG2 = 11
) (
    output cfg_arr_t wmask,
    output cfg_arr_t rstval
);

    function automatic logic [7:0] mask_of(input int unsigned idx);
        logic [31:0] m;
        int unsigned slot;
        if (idx >= 64) return 8'hFF;
        if (idx == CMD_OFF) return 8'h07;
        if (idx == 12 || idx == 60) return 8'hFF;
        if (idx >= BAR_BASE && idx <= BAR_TOP) begin
            slot = (idx - BAR_BASE) / 4;
            if (BAR_LOG2[slot] == 0) return 8'h00;
            m = ~((32'd1 << BAR_LOG2[slot]) - 32'd1);
            return m[8*(idx%4) +: 8];
        end
        if (idx >= ROM_BASE && idx < ROM_BASE + 4) begin
            if (ROM_LOG2 == 0) return 8'h00;
            m = ~((32'd1 << ROM_LOG2) - 32'd1) | 32'd1;
            return m[8*(idx%4) +: 8];
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] reset_of(input int unsigned idx);
        int unsigned slot;
        case (idx)
            0:  return VENDOR_ID[7:0];
            1:  return VENDOR_ID[15:8];
            2:  return DEVICE_ID[7:0];
            3:  return DEVICE_ID[15:8];
            8:  return REVISION;
            9:  return CLASS_CODE[7:0];
            10: return CLASS_CODE[15:8];
            11: return CLASS_CODE[23:16];
            61: return INT_PIN;
            default: ;
        endcase
        if (idx >= BAR_BASE && idx <= BAR_TOP && (idx % 4) == 0) begin
            slot = (idx - BAR_BASE) / 4;
            if (BAR_IO[slot] && BAR_LOG2[slot] != 0) return 8'h01;
        end
        return 8'h00;
    endfunction

    for (genvar i = 0; i < CFG_BYTES; i++) begin : g_attr
        assign wmask[i]  = mask_of(i);
        assign rstval[i] = reset_of(i);
    end

endmodule

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge
    import cfg_pkg::*;
(
    input  cfg_arr_t    cur,
    input  cfg_arr_t    wmask,
    input  logic        wr_en,
    input  logic [7:0]  off,
    input  width_e      w,
    input  logic [31:0] wdata,
    output cfg_arr_t    nxt,
    output logic        decode_chg
);

    logic [2:0] nb;
    assign nb = nbytes_of(w);

    for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
        logic [7:0] rel;
        logic       sel;
        logic [7:0] wb;
        assign rel = 8'(i) - off;
        assign sel = wr_en && (8'(i) >= off) && (rel < {5'd0, nb});
        assign wb  = wdata[8*rel[1:0] +: 8];
        assign nxt[i] = sel ? ((cur[i] & ~wmask[i]) | (wb & wmask[i])) : cur[i];
    end

    assign decode_chg = wr_en &&
        ((nxt[BAR_TOP:BAR_BASE] != cur[BAR_TOP:BAR_BASE]) ||
         (nxt[CMD_OFF][1:0] != cur[CMD_OFF][1:0]));

endmodule

// File: rtl/cfg_space.sv
module cfg_space
    import cfg_pkg::*;
#(
    parameter logic [7:0]  BUS_NUM    = 8'h00,
    parameter logic [7:0]  DEVFN      = 8'h08,
    parameter logic [15:0] VENDOR_ID  = 16'h1234,
    parameter logic [15:0] DEVICE_ID  = 16'h5678,
    parameter logic [7:0]  REVISION   = 8'h01,
    parameter logic [23:0] CLASS_CODE = 24'h020000,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter int unsigned BAR_LOG2 [BAR_SLOTS] = '{5, 12, 0, 0, 0, 0},
    parameter logic [BAR_SLOTS-1:0] BAR_IO = 6'b000001,
    parameter int unsigned ROM_LOG2   = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_vld,
    input  logic        req_we,
    input  logic [23:0] req_addr,
    input  logic [2:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rsp_vld,
    output logic [31:0] rsp_rdata,
    output logic        remap_pulse
);

    logic       hit;
    logic [7:0] off;
    width_e     req_w;
    width_e     rd_w;
    cfg_arr_t   wmask;
    cfg_arr_t   rstval;
    cfg_arr_t   merged;
    logic       decode_chg;
    logic [31:0] rd_val;

    cfg_state_t st_d;
    cfg_state_t st_q;
    cfg_state_t st_rst;

    cfg_decode #(
        .BUS_NUM (BUS_NUM),
        .DEVFN   (DEVFN)
    ) u_decode (
        .addr  (req_addr),
        .len   (req_len),
        .hit   (hit),
        .off   (off),
        .req_w (req_w),
        .rd_w  (rd_w)
    );

    cfg_attr #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .REVISION   (REVISION),
        .CLASS_CODE (CLASS_CODE),
        .INT_PIN    (INT_PIN),
        .BAR_LOG2   (BAR_LOG2),
        .BAR_IO     (BAR_IO),
        .ROM_LOG2   (ROM_LOG2)
    ) u_attr (
        .wmask  (wmask),
        .rstval (rstval)
    );

    cfg_lane_merge u_merge (
        .cur        (st_q.cfg),
        .wmask      (wmask),
        .wr_en      (req_vld && req_we && hit),
        .off        (off),
        .w          (req_w),
        .wdata      (req_wdata),
        .nxt        (merged),
        .decode_chg (decode_chg)
    );

    always_comb begin
        rd_val        = '0;
        rd_val[7:0]   = st_q.cfg[off];
        if (rd_w != W1) begin
            rd_val[15:8] = st_q.cfg[off + 8'd1];
        end
        if (rd_w == W4) begin
            rd_val[31:16] = {st_q.cfg[off + 8'd3], st_q.cfg[off + 8'd2]};
        end
    end

    always_comb begin
        st_rst         = '0;
        st_rst.cfg     = rstval;

        st_d           = st_q;
        st_d.rsp_vld   = 1'b0;
        st_d.remap     = 1'b0;
        if (req_vld && !req_we) begin
            st_d.rsp_vld = 1'b1;
            st_d.rdata   = hit ? rd_val : ones_of(req_w);
        end
        if (req_vld && req_we && hit) begin
            st_d.cfg   = merged;
            st_d.remap = decode_chg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_vld     = st_q.rsp_vld;
    assign rsp_rdata   = st_q.rdata;
    assign remap_pulse = st_q.remap;

    // Assertion support: high from the second clock after reset release.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_miss_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_vld && !req_we && !hit) |->
            rsp_rdata == ones_of(width_of($past(req_len))));

    p_miss_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_vld && req_we && !hit) |-> $stable(st_q.cfg));

    p_narrow_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(req_vld && !req_we && hit && req_addr[7:0] == 8'hFF) |->
            rsp_rdata[31:8] == 24'h0);

    p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && rsp_vld |-> $past(req_vld && !req_we));

    p_vendor_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> $stable(st_q.cfg[0]) && $stable(st_q.cfg[1]));

    p_remap_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && remap_pulse |-> $past(req_vld && req_we && hit));

    p_remap_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |-> !rsp_vld);

endmodule

// File: tb/cfg_space_tb.sv
`timescale 1ns/1ps
module cfg_space_tb_top;

    localparam logic [7:0]  TB_BUS   = 8'h02;
    localparam logic [7:0]  TB_DEVFN = 8'h40;
    localparam logic [15:0] TB_VEN   = 16'hC0DE;
    localparam logic [15:0] TB_DEV   = 16'h5A17;
    localparam logic [7:0]  TB_REV   = 8'h03;
    localparam logic [23:0] TB_CLASS = 24'h020000;
    localparam logic [7:0]  TB_PIN   = 8'h01;
    localparam int unsigned TB_LOG2 [6] = '{5, 12, 20, 0, 8, 0};
    localparam logic [5:0]  TB_IO    = 6'b010001;
    localparam int unsigned TB_ROM   = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [2:0]  req_len = 3'd1;
    logic [31:0] req_wdata = '0;
    logic        rsp_vld;
    logic [31:0] rsp_rdata;
    logic        remap_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] mdl [256];

    always #10 clk = ~clk;

    cfg_space #(
        .BUS_NUM    (TB_BUS),
        .DEVFN      (TB_DEVFN),
        .VENDOR_ID  (TB_VEN),
        .DEVICE_ID  (TB_DEV),
        .REVISION   (TB_REV),
        .CLASS_CODE (TB_CLASS),
        .INT_PIN    (TB_PIN),
        .BAR_LOG2   (TB_LOG2),
        .BAR_IO     (TB_IO),
        .ROM_LOG2   (TB_ROM)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vld     (req_vld),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .req_wdata   (req_wdata),
        .rsp_vld     (rsp_vld),
        .rsp_rdata   (rsp_rdata),
        .remap_pulse (remap_pulse)
    );

    function automatic logic [7:0] bmask(input int idx);
        logic [31:0] m;
        if (idx >= 64) return 8'hFF;
        if (idx == 4) return 8'h07;
        if (idx == 12 || idx == 60) return 8'hFF;
        if (idx >= 16 && idx < 40) begin
            if (TB_LOG2[(idx-16)/4] == 0) return 8'h00;
            m = ~((32'd1 << TB_LOG2[(idx-16)/4]) - 32'd1);
            return m[8*(idx%4) +: 8];
        end
        if (idx >= 48 && idx < 52) begin
            m = ~((32'd1 << TB_ROM) - 32'd1) | 32'd1;
            return m[8*(idx%4) +: 8];
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] breset(input int idx);
        case (idx)
            0: return TB_VEN[7:0];
            1: return TB_VEN[15:8];
            2: return TB_DEV[7:0];
            3: return TB_DEV[15:8];
            8: return TB_REV;
            9: return TB_CLASS[7:0];
            10: return TB_CLASS[15:8];
            11: return TB_CLASS[23:16];
            61: return TB_PIN;
            default: ;
        endcase
        if (idx >= 16 && idx < 40 && idx % 4 == 0 &&
            TB_IO[(idx-16)/4] && TB_LOG2[(idx-16)/4] != 0) return 8'h01;
        return 8'h00;
    endfunction

    function automatic int req_bytes(input logic [2:0] len);
        return (len == 3'd1) ? 1 : (len == 3'd2) ? 2 : 4;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mdl[i] = breset(i);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drives one request at a falling edge and checks the response at the next one.
    task automatic acc(input bit we, input logic [7:0] bus, input logic [7:0] dvf,
                       input logic [7:0] off, input logic [2:0] len,
                       input logic [31:0] wd, input string tag);
        bit hit;
        int n;
        int o;
        logic [31:0] exp_rd;
        logic [7:0] nm [256];
        bit exp_remap;
        hit = (bus == TB_BUS) && (dvf == TB_DEVFN);
        o = int'(off);
        n = req_bytes(len);
        exp_rd = '0;
        if (!hit) begin
            exp_rd = (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        end else begin
            if (n == 4 && o > 252) n = 2;
            if (n == 2 && o > 254) n = 1;
            for (int k = 0; k < n; k++) exp_rd[8*k +: 8] = mdl[o+k];
        end
        for (int i = 0; i < 256; i++) nm[i] = mdl[i];
        exp_remap = 1'b0;
        if (we && hit) begin
            for (int k = 0; k < req_bytes(len); k++) begin
                if (o + k <= 255)
                    nm[o+k] = (mdl[o+k] & ~bmask(o+k)) | (wd[8*k +: 8] & bmask(o+k));
            end
            for (int i = 16; i < 40; i++) if (nm[i] != mdl[i]) exp_remap = 1'b1;
            if (nm[4][1:0] != mdl[4][1:0]) exp_remap = 1'b1;
        end
        req_vld   = 1'b1;
        req_we    = we;
        req_addr  = {bus, dvf, off};
        req_len   = len;
        req_wdata = wd;
        @(negedge clk);
        if (!we) begin
            chk(rsp_vld === 1'b1, {tag, " rsp_vld"}, {31'd0, rsp_vld}, 32'd1);
            chk(rsp_rdata === exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
        end else begin
            chk(rsp_vld === 1'b0, {tag, " rsp_vld R4"}, {31'd0, rsp_vld}, 32'd0);
        end
        chk(remap_pulse === exp_remap, {tag, " remap R9"}, {31'd0, remap_pulse},
            {31'd0, exp_remap});
        for (int i = 0; i < 256; i++) mdl[i] = nm[i];
    endtask

    task automatic idle(input string tag);
        req_vld = 1'b0;
        req_we  = 1'b0;
        @(negedge clk);
        chk(rsp_vld === 1'b0 && remap_pulse === 1'b0, tag,
            {30'd0, rsp_vld, remap_pulse}, 32'd0);
    endtask

    task automatic rd(input logic [7:0] off, input logic [2:0] len, input string tag);
        acc(1'b0, TB_BUS, TB_DEVFN, off, len, 32'h0, tag);
    endtask

    task automatic wr(input logic [7:0] off, input logic [2:0] len,
                      input logic [31:0] wd, input string tag);
        acc(1'b1, TB_BUS, TB_DEVFN, off, len, wd, tag);
    endtask

    task automatic do_reset();
        req_vld = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        int seed;
        logic [31:0] r;
        logic [7:0] ro;
        logic [7:0] rb;
        logic [7:0] rdv;
        model_reset();
        @(negedge clk);
        do_reset();

        // R10: reset contents
        rd(8'h00, 3'd2, "R10 vendor");
        rd(8'h02, 3'd2, "R10 device");
        rd(8'h08, 3'd4, "R10 rev/class");
        rd(8'h10, 3'd4, "R10 R6 io bar0");
        rd(8'h20, 3'd4, "R10 io bar4");
        rd(8'h3C, 3'd4, "R10 intpin");
        idle("R4 idle no response");

        // R1: misses return ones at requested width
        acc(1'b0, 8'h00, TB_DEVFN, 8'h00, 3'd1, 0, "R1 miss len1");
        acc(1'b0, 8'h00, TB_DEVFN, 8'h00, 3'd2, 0, "R1 miss len2");
        acc(1'b0, TB_BUS, 8'h48, 8'hFF, 3'd4, 0, "R1 miss len4");
        acc(1'b0, TB_BUS, 8'h41, 8'h10, 3'd3, 0, "R1 miss code3");

        // R2: missing write changes nothing
        acc(1'b1, 8'h03, TB_DEVFN, 8'h14, 3'd4, 32'hFFFF_FFFF, "R2 miss write");
        acc(1'b1, TB_BUS, 8'h00, 8'h44, 3'd4, 32'h1234_5678, "R2 miss write2");
        rd(8'h14, 3'd4, "R2 bar1 unchanged");
        rd(8'h44, 3'd4, "R2 0x44 unchanged");

        // R6: sizing
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, "R6 bar1 size");
        rd(8'h14, 3'd4, "R6 bar1 FFFFF000");
        wr(8'h18, 3'd4, 32'hFFFF_FFFF, "R6 bar2 size");
        rd(8'h18, 3'd4, "R6 bar2 FFF00000");
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, "R6 io bar0 size");
        rd(8'h10, 3'd4, "R6 io bar0 FFFFFFE1");
        wr(8'h1C, 3'd4, 32'hFFFF_FFFF, "R6 empty bar3");
        rd(8'h1C, 3'd4, "R6 empty bar3 zero");
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, "R9 same value no remap");

        // R7: ROM
        wr(8'h30, 3'd4, 32'hFFFF_FFFF, "R7 rom size");
        rd(8'h30, 3'd4, "R7 rom FFFFF801");

        // R8: command and misc
        wr(8'h04, 3'd2, 32'h0000_FFFF, "R8 command");
        rd(8'h04, 3'd2, "R8 command 0007");
        wr(8'h04, 3'd1, 32'h0000_0004, "R8 R9 master only toggles");
        wr(8'h0C, 3'd1, 32'h0000_00A5, "R8 cacheline");
        rd(8'h0C, 3'd1, "R8 cacheline A5");
        wr(8'h3C, 3'd2, 32'h0000_7777, "R8 intline");
        rd(8'h3C, 3'd2, "R8 intline/pin");
        wr(8'h00, 3'd4, 32'h0, "R8 vendor ro");
        rd(8'h00, 3'd4, "R8 vendor kept");

        // R4/R5: little-endian lanes
        wr(8'h80, 3'd4, 32'hDDCC_BBAA, "R5 write 0x80");
        rd(8'h80, 3'd1, "R4 byte AA");
        rd(8'h81, 3'd2, "R4 half CCBB");
        rd(8'h80, 3'd4, "R4 word");

        // R3/R5: top of space
        wr(8'hFC, 3'd4, 32'h4433_2211, "R5 top word");
        wr(8'hFE, 3'd4, 32'h9988_7766, "R5 clipped write");
        rd(8'hFC, 3'd4, "R3 full at FC");
        rd(8'hFD, 3'd4, "R3 FD narrow to 2");
        rd(8'hFF, 3'd4, "R3 FF narrow to 1");
        rd(8'hFE, 3'd2, "R3 FE len2");
        rd(8'hFF, 3'd2, "R3 FF len2 to 1");
        idle("R9 idle");

        // R10: reset restores
        do_reset();
        rd(8'h14, 3'd4, "R10 bar1 after reset");
        rd(8'h04, 3'd2, "R10 command after reset");
        rd(8'h80, 3'd4, "R10 0x80 after reset");

        // Constrained random
        seed = 32'h5EED;
        r = $urandom(seed);
        for (int it = 0; it < 2000; it++) begin
            r = $urandom();
            ro = (r[0]) ? {2'b00, 6'($urandom_range(0, 63))} : 8'($urandom_range(0, 255));
            rb = (r[4:1] == 0) ? 8'h00 : TB_BUS;
            rdv = (r[8:5] == 0) ? 8'h48 : TB_DEVFN;
            acc(r[9], rb, rdv, ro, 3'(r[12:10]), $urandom(), "R5 R9 random");
            if (r[15:13] == 0) idle("R4 random idle");
        end
        idle("final idle");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %08h expected %08h", 32'd0, 32'd1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule